// File: doc/BRIEF.md
# Five-Level Multicarrier PWM Modulator

This block produces the eight gate commands for one phase leg of a five-level cascaded inverter. The leg is built from two H-bridges in series, named bridge A and bridge B. Each bridge contributes -1, 0 or +1 unit of DC voltage, so the phase can sit at one of five levels from -2 to +2. A signed reference sample is compared against four triangular carriers. The mode input chooses how those carriers are placed. In the three level-shifted arrangements the carriers are stacked in bands: all in phase, the two upper bands inverted against the two lower ones, or every band inverted against its neighbour. In the phase-shifted arrangement there are two full-range carriers a quarter period apart, one for each bridge.

All carriers come from a single phase counter. It runs from 0 to 2P-1, where P is the half-period input. It is folded into a triangle from 0 up to P and back. The level-shifted carriers are this triangle (or P minus it) offset into one of four bands of height P. The phase-shifted carriers are the triangle scaled by four and centred on zero. The reference uses the same scale: it runs from -2P to +2P. To get 10 kHz switching, set P to half the number of system clocks in one switching period.

Top module: `pwm5_modulator`

## Requirements
- R1: While rst is high, and on the first cycle after it falls, gate_o equals 8'hAA. This means every high-side switch is off, every low-side switch is on, and both bridges output 0.
- R2: The phase counter counts 0..2P-1 and then wraps to 0. P is the value of half_per_i captured in reset or at the wrap. With an even P, one carrier period is 2P clocks.
- R3: Mode 2'b00 (in-phase stack). Carrier k (k=0..3, lowest band first) equals (k-2)*P + t, where t is the triangle (phase if phase<=P, otherwise 2P-phase).
- R4: Mode 2'b01 (opposed stack). Carriers 2 and 3 use t. Carriers 0 and 1 use P-t. Both keep the band offset (k-2)*P.
- R5: Mode 2'b10 (alternating stack). Even-numbered carriers use t and odd-numbered carriers use P-t. All keep the band offset (k-2)*P.
- R6: Mode 2'b11 (shifted pair). Let a=4t-2P. Let b be the same quantity computed from the phase advanced by floor(P/2), modulo 2P. Carrier 3 is a, carrier 0 is -a, carrier 2 is b and carrier 1 is -b. With a zero reference, both bridges stay at 0.
- R7: A change on mode_i takes effect only from the cycle after a carrier period wraps.
- R8: Comparator k goes to 1 when the reference is strictly above carrier k and to 0 when it is strictly below. When the two are equal it keeps its previous value.
- R9: The leg states are: bridge A leg 1 = q3, leg 2 = not q0; bridge B leg 1 = q2, leg 2 = not q1. gate_o bits are [0] A1 high, [1] A1 low, [2] A2 high, [3] A2 low, [4..7] the same order for bridge B. A high-side bit equals its leg state and the matching low-side bit is its complement. Each bridge outputs leg1 - leg2. The comparators update on the clock edge after the reference and phase they use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | RW | Signed reference sample, full scale -2P..+2P |
| mode_i | input | 2 | Carrier arrangement: 0 in-phase, 1 opposed, 2 alternating, 3 shifted pair |
| half_per_i | input | CW | Carrier half period P in clocks |
| gate_o | output | 8 | Switch commands for the two bridges |

## Verification
The bench runs a reference model built from the carrier equations and compares every output word against it. Because of this, a wrong phase count, a wrong mode latch or a carrier in the wrong band shows up at gate_o within one carrier period. It shows up the first time the reference crosses the affected carrier. A broken hold-on-equal rule shows up only when the reference sits exactly on a carrier peak or valley. Directed cases at +2P and -2P expose it within one period as a single flip of the outer leg. A bridge mapping error shows up on the very next edge as a wrong level.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  typedef enum logic [1:0] {
    CM_STACK_SAME = 2'b00,
    CM_STACK_OPP  = 2'b01,
    CM_STACK_ALT  = 2'b10,
    CM_SHIFT_PAIR = 2'b11
  } car_mode_e;

  localparam int NCMP = 4;
  localparam logic [NCMP-1:0] CMP_RST = 4'b0011;
endpackage

// File: rtl/pwm5_carrier_gen.sv
module pwm5_carrier_gen
  import pwm5_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] half_per_i,
  input  logic [1:0]    mode_i,
  output logic [CW:0]   ph_o,
  output logic [CW-1:0] per_o,
  output car_mode_e     mode_o,
  output logic          wrap_o
);
  logic [CW:0]   ph_q;
  logic [CW-1:0] per_q;
  car_mode_e     mode_q;
  logic [CW+1:0] ph_inc;
  logic [CW+1:0] lim;

  assign ph_inc = {1'b0, ph_q} + (CW+2)'(1);
  assign lim    = {1'b0, per_q, 1'b0};
  assign wrap_o = (ph_inc >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      per_q  <= half_per_i;
      mode_q <= car_mode_e'(mode_i);
    end else if (wrap_o) begin
      ph_q   <= '0;
      per_q  <= half_per_i;
      mode_q <= car_mode_e'(mode_i);
    end else begin
      ph_q   <= ph_inc[CW:0];
    end
  end

  assign ph_o   = ph_q;
  assign per_o  = per_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/pwm5_carrier_map.sv
module pwm5_carrier_map
  import pwm5_pkg::*;
#(
  parameter int CW = 12,
  parameter int EW = CW + 4
) (
  input  logic [CW:0]          ph_i,
  input  logic [CW-1:0]        per_i,
  input  car_mode_e            mode_i,
  output logic signed [EW-1:0] car_o [NCMP]
);
  logic [CW:0]   p2;
  logic [CW:0]   half;
  logic [CW+1:0] ph_sh;
  logic [CW:0]   ph_b;
  logic [CW:0]   t_a;
  logic [CW:0]   t_b;

  function automatic logic [CW:0] fold(input logic [CW:0] p,
                                       input logic [CW:0] h,
                                       input logic [CW:0] full);
    return (p <= h) ? p : (full - p);
  endfunction

  assign p2    = {per_i, 1'b0};
  assign half  = {1'b0, per_i};
  assign ph_sh = {1'b0, ph_i} + (CW+2)'(per_i >> 1);
  assign ph_b  = (ph_sh >= {1'b0, p2}) ? (CW+1)'(ph_sh - {1'b0, p2})
                                       : (CW+1)'(ph_sh);
  assign t_a   = fold(ph_i, half, p2);
  assign t_b   = fold(ph_b, half, p2);

  logic signed [EW-1:0] tv, tvb, pv, iv, two_p, pair_a, pair_b;
  assign tv     = signed'(EW'(t_a));
  assign tvb    = signed'(EW'(t_b));
  assign pv     = signed'(EW'(per_i));
  assign iv     = pv - tv;
  assign two_p  = pv <<< 1;
  assign pair_a = (tv <<< 2) - two_p;
  assign pair_b = (tvb <<< 2) - two_p;

  for (genvar k = 0; k < NCMP; k++) begin : g_car
    localparam logic signed [EW-1:0] OFS = EW'(k - 2);
    localparam bit UP_OPP  = (k >= 2);
    localparam bit UP_ALT  = ((k % 2) == 0);
    localparam bit USE_B   = (k == 1) || (k == 2);
    localparam bit NEGATE  = (k < 2);
    logic signed [EW-1:0] base;
    logic signed [EW-1:0] pair;
    assign base = OFS * pv;
    assign pair = USE_B ? pair_b : pair_a;

    always_comb begin
      unique case (mode_i)
        CM_STACK_SAME: car_o[k] = base + tv;
        CM_STACK_OPP:  car_o[k] = base + (UP_OPP ? tv : iv);
        CM_STACK_ALT:  car_o[k] = base + (UP_ALT ? tv : iv);
        default:       car_o[k] = NEGATE ? -pair : pair;
      endcase
    end
  end
endmodule

// File: rtl/pwm5_cmp_bank.sv
module pwm5_cmp_bank #(
  parameter int XW = 17,
  parameter int N  = 4,
  parameter logic [N-1:0] RST_Q = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [XW-1:0] ref_i,
  input  logic signed [XW-1:0] car_i [N],
  output logic [N-1:0]         q_o
);
  for (genvar k = 0; k < N; k++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) begin
        q_o[k] <= RST_Q[k];
      end else if (ref_i > car_i[k]) begin
        q_o[k] <= 1'b1;
      end else if (ref_i < car_i[k]) begin
        q_o[k] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm5_modulator.sv
module pwm5_modulator
  import pwm5_pkg::*;
#(
  parameter int RW = 16,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [RW-1:0] ref_i,
  input  logic [1:0]           mode_i,
  input  logic [CW-1:0]        half_per_i,
  output logic [7:0]           gate_o
);
  localparam int EW = CW + 4;
  localparam int XW = ((RW > EW) ? RW : EW) + 1;

  logic [CW:0]          ph_w;
  logic [CW-1:0]        per_w;
  car_mode_e            mode_w;
  logic                 wrap_w;
  logic signed [EW-1:0] car_w [NCMP];
  logic signed [XW-1:0] car_x [NCMP];
  logic signed [XW-1:0] ref_x;
  logic [NCMP-1:0]      q_w;

  pwm5_carrier_gen #(.CW(CW)) gen_i (
    .clk(clk), .rst(rst), .half_per_i(half_per_i), .mode_i(mode_i),
    .ph_o(ph_w), .per_o(per_w), .mode_o(mode_w), .wrap_o(wrap_w)
  );

  pwm5_carrier_map #(.CW(CW), .EW(EW)) map_i (
    .ph_i(ph_w), .per_i(per_w), .mode_i(mode_w), .car_o(car_w)
  );

  assign ref_x = XW'(ref_i);
  for (genvar k = 0; k < NCMP; k++) begin : g_ext
    assign car_x[k] = XW'(car_w[k]);
  end

  pwm5_cmp_bank #(.XW(XW), .N(NCMP), .RST_Q(CMP_RST)) cmp_i (
    .clk(clk), .rst(rst), .ref_i(ref_x), .car_i(car_x), .q_o(q_w)
  );

  logic leg_a1, leg_a2, leg_b1, leg_b2;
  assign leg_a1 = q_w[3];
  assign leg_a2 = ~q_w[0];
  assign leg_b1 = q_w[2];
  assign leg_b2 = ~q_w[1];

  assign gate_o = {~leg_b2, leg_b2, ~leg_b1, leg_b1,
                   ~leg_a2, leg_a2, ~leg_a1, leg_a1};
endmodule

// File: rtl/pwm5_modulator_chk.sv
module pwm5_modulator_chk
  import pwm5_pkg::*;
#(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    gate_o,
  input logic [CW:0]   ph,
  input logic [CW-1:0] per,
  input car_mode_e     mode,
  input logic          wrap
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> gate_o == 8'hAA);                                   // R1
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (per != '0) |-> ({1'b0, ph} < {1'b0, per, 1'b0}));                 // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ph == '0);                                                // R2
  AST_PERIOD_STEADY: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(per));                                           // R2
  AST_MODE_STEADY: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(mode));                                          // R7
endmodule

bind pwm5_modulator pwm5_modulator_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .gate_o(gate_o), .ph(ph_w), .per(per_w),
  .mode(mode_w), .wrap(wrap_w)
);

// File: tb/pwm5_modulator_tb_top.sv
module pwm5_modulator_tb_top;
  localparam int RW = 16;
  localparam int CW = 12;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [RW-1:0] ref_i = '0;
  logic [1:0]           mode_i = 2'd0;
  logic [CW-1:0]        half_per_i = CW'(8);
  logic [7:0]           gate_o;

  always #2 clk = ~clk;

  pwm5_modulator #(.RW(RW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .ref_i(ref_i), .mode_i(mode_i),
    .half_per_i(half_per_i), .gate_o(gate_o)
  );

  int    n_run = 0;
  int    n_fail = 0;
  int    cyc = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  typedef struct {
    logic [7:0] g;
    string      tag;
  } sb_item_t;
  sb_item_t sbq[$];

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: gate_o actual %02h expected %02h at cycle %0d",
               tag, act, exp, cyc);
    end
  endtask

  function automatic int tri_of(int ph, int p);
    return (ph <= p) ? ph : 2 * p - ph;
  endfunction

  function automatic int carrier(int k, int md, int ph, int p);
    int t, inv, ph2, a, b;
    t   = tri_of(ph, p);
    inv = p - t;
    ph2 = ph + p / 2;
    if (ph2 >= 2 * p) ph2 -= 2 * p;
    a = 4 * t - 2 * p;
    b = 4 * tri_of(ph2, p) - 2 * p;
    case (md)
      0: return (k - 2) * p + t;
      1: return (k - 2) * p + ((k >= 2) ? t : inv);
      2: return (k - 2) * p + (((k % 2) == 0) ? t : inv);
      default: begin
        if (k == 3) return a;
        if (k == 0) return -a;
        if (k == 2) return b;
        return -b;
      end
    endcase
  endfunction

  // reference model: advances on each edge, pushes the expected gate word
  int         mph, mp, mmd;
  logic [3:0] mq;
  always @(posedge clk) begin
    sb_item_t it;
    if (rst) begin
      mph = 0;
      mp  = int'(half_per_i);
      mmd = int'(mode_i);
      mq  = 4'b0011;
    end else begin
      for (int k = 0; k < 4; k++) begin
        int c;
        c = carrier(k, mmd, mph, mp);
        if (int'(ref_i) > c) mq[k] = 1'b1;
        else if (int'(ref_i) < c) mq[k] = 1'b0;
      end
      if (mph + 1 >= 2 * mp) begin
        mph = 0;
        mp  = int'(half_per_i);
        mmd = int'(mode_i);
      end else begin
        mph = mph + 1;
      end
    end
    it.g   = {mq[1], ~mq[1], ~mq[2], mq[2], mq[0], ~mq[0], ~mq[3], mq[3]};
    it.tag = cur_tag;
    sbq.push_back(it);
  end

  // monitor: compares one item per cycle away from the active edge
  always @(negedge clk) begin
    if (!done && sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      check(gate_o === it.g, it.tag, gate_o, it.g);
    end
  end

  function automatic int level_of(logic [7:0] g);
    return (int'(g[0]) - int'(g[2])) + (int'(g[4]) - int'(g[6]));
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ramp(int lo, int hi, int hold);
    for (int v = lo; v <= hi; v++) begin
      ref_i = RW'(v);
      tick(hold);
    end
    for (int v = hi; v >= lo; v--) begin
      ref_i = RW'(v);
      tick(hold);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bit ok;
    tick(5);
    // R1: reset state
    check(gate_o == 8'hAA, "R1 reset", gate_o, 8'hAA);
    rst = 1'b0;
    tick(1);
    check(gate_o == 8'hAA, "R1 first cycle", gate_o, 8'hAA);

    cur_tag = "R3";
    ramp(-18, 18, 3);
    mode_i = 2'd1; cur_tag = "R7";
    tick(20);
    cur_tag = "R4";
    ramp(-18, 18, 3);
    mode_i = 2'd2; cur_tag = "R7";
    tick(20);
    cur_tag = "R5";
    ramp(-18, 18, 3);
    mode_i = 2'd3; cur_tag = "R7";
    tick(20);
    cur_tag = "R6";
    ramp(-18, 18, 3);

    // R6: zero reference keeps both bridges at 0
    ref_i = '0;
    tick(20);
    ok = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (level_of(gate_o) != 0 || gate_o[0] != gate_o[2]) ok = 1'b0;
      tick(1);
    end
    check(ok, "R6 zero reference", gate_o, gate_o);

    // R2: period changes, odd and larger
    cur_tag = "R2";
    mode_i = 2'd0;
    half_per_i = CW'(5);
    tick(30);
    ramp(-11, 11, 2);
    half_per_i = CW'(11);
    tick(30);
    ramp(-23, 23, 2);

    // R9 and R8: full scale positive, then exactly on the carrier peak
    half_per_i = CW'(8);
    cur_tag = "R9";
    ref_i = RW'(17);
    tick(40);
    check(gate_o == 8'h99, "R9 level +2 pattern", gate_o, 8'h99);
    check(level_of(gate_o) == 2, "R9 level +2", gate_o, 8'h99);
    cur_tag = "R8";
    ref_i = RW'(16);
    ok = 1'b1;
    for (int i = 0; i < 34; i++) begin
      tick(1);
      if (gate_o != 8'h99) ok = 1'b0;
    end
    check(ok, "R8 hold at +2P", gate_o, 8'h99);
    ref_i = RW'(-17);
    tick(20);
    check(gate_o == 8'h66, "R9 level -2 pattern", gate_o, 8'h66);
    ref_i = RW'(-16);
    ok = 1'b1;
    for (int i = 0; i < 34; i++) begin
      tick(1);
      if (level_of(gate_o) != -2) ok = 1'b0;
    end
    check(ok, "R8 hold at -2P", gate_o, 8'h66);

    // R7: mode requests land mid period, applied only at the wrap
    cur_tag = "R7";
    ref_i = RW'(3);
    for (int i = 0; i < 16; i++) begin
      mode_i = 2'(i);
      ref_i  = RW'((i * 5) % 31 - 15);
      tick(7);
    end
    tick(4);
    finish_run();
  end
endmodule